// File: doc/BRIEF.md
# Phase-Error Digitizer and Loop Controller for an All-Digital PLL

This block is the digital control path of an all-digital phase-locked loop. It runs on the internal oscillator clock. A free-running binary divider of `DIV_W` bits divides that clock by 2^DIV_W. On each rising edge of the reference input, the three most significant divider bits are captured and turned into a signed phase-error code. The code has eight levels and no zero level. A proportional-plus-derivative correction is built from the code and from the previous code, then clamped.

The clamped correction leaves the block as a serial train of single-cycle Up or Down pulses, one pulse per unit of correction. A cell-mode register turns the pulses into a slow/fast control word for a ring of `NCELL` identical tunable delay cells. The register does not fix which cell switches next: a rotating search pointer picks the cell. Because of this, pulses can arrive back to back in consecutive cycles. The oscillator is not part of the block.

Top module: `adpll_ctrl`

## Requirements
- R1: While rst_ni is low, cw_o is all zeros (every cell slow), up_o and dn_o are low, and err_vld_o is low.
- R2: The divider counts up by one on every clock and wraps at 2^DIV_W. A reference edge is a cycle in which ref_i is 1 after a cycle in which it was 0. The divider value present at that edge is captured, and err_vld_o is high for exactly the one following cycle. At all other times err_vld_o is low.
- R3: With s = the three top divider bits captured at the edge, err_code_o is 4-bit two's complement. When s[2]=0 it is -(s[1:0]+1), meaning the internal clock is early. When s[2]=1 it is +((3-s[1:0])+1), meaning the internal clock is late. The code is therefore one of ±1..±4 and is never zero.
- R4: One cycle after err_vld_o, corr_o (4-bit two's complement) equals 2*code - prev, clamped to [-4,+4]. Here prev is the previous valid code, or 0 after reset.
- R5: Each correction c produces exactly |c| pulses: up_o if c>0, dn_o if c<0. The pulses come in consecutive cycles, starting two cycles after the err_vld_o cycle. up_o and dn_o are never high together.
- R6: A cycle with up_o high and fewer than NCELL fast cells turns exactly one slow cell fast at the next clock. With all cells fast, the pulse leaves cw_o unchanged.
- R7: A cycle with dn_o high and at least one fast cell turns exactly one fast cell slow at the next clock. With all cells slow, the pulse leaves cw_o unchanged.
- R8: In a cycle with neither pulse, cw_o holds its value.
- R9: Consider a closed loop whose oscillator period falls linearly with the number of fast cells, started 180 degrees off. The first code has magnitude 4. From the 60th reference period on, every code lies within ±3, and codes of both signs keep appearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Reference clock, sampled on clk_i |
| err_code_o | output | 4 | Signed phase-error code |
| err_vld_o | output | 1 | Single-cycle strobe marking a new code |
| corr_o | output | 4 | Clamped PD correction |
| up_o | output | 1 | Speed-up pulse |
| dn_o | output | 1 | Slow-down pulse |
| cw_o | output | NCELL | Per-cell mode, 1 = fast |

## Verification
Two events can fall in the same cycle. The first is a reference edge that lands on the divider's wraparound, which is where the code flips from +1 to -1. The second is a pulse that arrives while the cell register is already saturated. The bench provokes the first by sweeping the reference spacing, so that the edge walks through every divider residue in steps of +1, -3 and +3. It judges the result by comparing each code with a value it derives arithmetically from its own count of elapsed clocks. It provokes the second through corrections that clamp at ±4 and through long runs of one sign. The pulse count and the number of fast cells it models must then match the ports in every cycle.

// File: rtl/adpll_pkg.sv
package adpll_pkg;
  localparam int CODE_W = 4;
  typedef logic signed [CODE_W-1:0] code_t;

  // sign-magnitude decode of the top three divider bits; no zero level
  function automatic code_t quantize(input logic [2:0] s);
    logic [2:0] mag;
    mag = s[2] ? ({1'b0, ~s[1:0]} + 3'd1) : ({1'b0, s[1:0]} + 3'd1);
    return s[2] ? code_t'({1'b0, mag}) : -code_t'({1'b0, mag});
  endfunction
endpackage

// File: rtl/adpll_div.sv
module adpll_div #(
  parameter int DIV_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] top_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + ONE;
  end

  assign top_o = cnt_q[DIV_W-1 -: 3];
endmodule

// File: rtl/adpll_quant.sv
module adpll_quant
  import adpll_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_i,
  input  logic [2:0] top_i,
  output code_t      code_o,
  output logic       vld_o
);
  logic ref_q;
  logic edge_w;

  assign edge_w = ref_i & ~ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      vld_o  <= 1'b0;
      code_o <= '0;
    end else begin
      ref_q <= ref_i;
      vld_o <= edge_w;
      if (edge_w) code_o <= quantize(top_i);
    end
  end
endmodule

// File: rtl/adpll_pd.sv
module adpll_pd
  import adpll_pkg::*;
#(
  parameter int CORR_MAX = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t code_i,
  input  logic  vld_i,
  output code_t corr_o,
  output logic  vld_o
);
  localparam int SUM_W = CODE_W + 2;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'(CORR_MAX);

  code_t                   prev_q;
  code_t                   sat;
  logic signed [SUM_W-1:0] sum;

  // P + D = code + (code - prev)
  always_comb begin
    sum = (SUM_W'(code_i) <<< 1) - SUM_W'(prev_q);
    if (sum > HI)       sat = code_t'(CORR_MAX);
    else if (sum < -HI) sat = -code_t'(CORR_MAX);
    else                sat = code_t'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      corr_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        prev_q <= code_i;
        corr_o <= sat;
      end
    end
  end
endmodule

// File: rtl/adpll_ser.sv
module adpll_ser
  import adpll_pkg::*;
#(
  parameter int CORR_MAX = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t corr_i,
  input  logic  vld_i,
  output logic  up_o,
  output logic  dn_o
);
  localparam int RW = $clog2(CORR_MAX + 1);

  logic [RW-1:0] rem_q;
  logic          dir_up_q;
  code_t         mag;
  logic          busy;

  assign mag  = corr_i[CODE_W-1] ? -corr_i : corr_i;
  assign busy = (rem_q != '0);
  assign up_o = busy & dir_up_q;
  assign dn_o = busy & ~dir_up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q    <= '0;
      dir_up_q <= 1'b0;
    end else if (vld_i) begin
      rem_q    <= RW'(mag);
      dir_up_q <= ~corr_i[CODE_W-1];
    end else if (busy) begin
      rem_q <= rem_q - RW'(1);
    end
  end
endmodule

// File: rtl/adpll_cw.sv
module adpll_cw #(
  parameter int NCELL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [NCELL-1:0] cw_o
);
  localparam int PW = (NCELL > 1) ? $clog2(NCELL) : 1;

  logic [PW-1:0]    ptr_q;
  logic [PW-1:0]    set_idx, clr_idx;
  logic             set_ok, clr_ok;
  logic [NCELL-1:0] set_vec, clr_vec;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] i);
    return (i == PW'(NCELL - 1)) ? '0 : i + PW'(1);
  endfunction

  // rotating search from ptr_q: first slow cell for up, first fast cell for down
  always_comb begin
    int j;
    set_idx = '0;
    clr_idx = '0;
    set_ok  = 1'b0;
    clr_ok  = 1'b0;
    for (int k = 0; k < NCELL; k++) begin
      j = (int'(ptr_q) + k) % NCELL;
      if (!set_ok && !cw_o[j]) begin
        set_ok  = 1'b1;
        set_idx = PW'(j);
      end
      if (!clr_ok && cw_o[j]) begin
        clr_ok  = 1'b1;
        clr_idx = PW'(j);
      end
    end
  end

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    assign set_vec[g] = up_i & set_ok & (set_idx == PW'(g));
    assign clr_vec[g] = dn_i & ~up_i & clr_ok & (clr_idx == PW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cw_o[g] <= 1'b0;
      else if (set_vec[g]) cw_o[g] <= 1'b1;
      else if (clr_vec[g]) cw_o[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ptr_q <= '0;
    else if (up_i && set_ok)   ptr_q <= nxt(set_idx);
    else if (dn_i && clr_ok)   ptr_q <= nxt(clr_idx);
  end
endmodule

// File: rtl/adpll_ctrl.sv
module adpll_ctrl
  import adpll_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int NCELL    = 4,
  parameter int CORR_MAX = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ref_i,
  output logic [adpll_pkg::CODE_W-1:0]  err_code_o,
  output logic                          err_vld_o,
  output logic [adpll_pkg::CODE_W-1:0]  corr_o,
  output logic                          up_o,
  output logic                          dn_o,
  output logic [NCELL-1:0]              cw_o
);
  logic [2:0] top;
  code_t      code;
  code_t      corr;
  logic       code_vld;
  logic       corr_vld;

  adpll_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .top_o (top)
  );

  adpll_quant u_quant (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_i),
    .top_i (top),
    .code_o(code),
    .vld_o (code_vld)
  );

  adpll_pd #(.CORR_MAX(CORR_MAX)) u_pd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(code),
    .vld_i (code_vld),
    .corr_o(corr),
    .vld_o (corr_vld)
  );

  adpll_ser #(.CORR_MAX(CORR_MAX)) u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .corr_i(corr),
    .vld_i (corr_vld),
    .up_o  (up_o),
    .dn_o  (dn_o)
  );

  adpll_cw #(.NCELL(NCELL)) u_cw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .up_i  (up_o),
    .dn_i  (dn_o),
    .cw_o  (cw_o)
  );

  assign err_code_o = code;
  assign err_vld_o  = code_vld;
  assign corr_o     = corr;
endmodule

// File: rtl/adpll_ctrl_chk.sv
module adpll_ctrl_chk #(
  parameter int NCELL = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       err_code_o,
  input logic             err_vld_o,
  input logic             up_o,
  input logic             dn_o,
  input logic [NCELL-1:0] cw_o
);
  // R3
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |-> ($signed(err_code_o) != 0 && $signed(err_code_o) >= -4 && $signed(err_code_o) <= 4));

  // R2
  vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |=> !err_vld_o);

  // R5
  no_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  // R6
  up_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && $countones(cw_o) < NCELL) |=> ($countones(cw_o) == $past($countones(cw_o)) + 1));

  // R6
  up_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && (&cw_o)) |=> $stable(cw_o));

  // R7
  dn_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_o && (|cw_o)) |=> ($countones(cw_o) + 1 == $past($countones(cw_o))));

  // R7
  dn_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_o && !(|cw_o)) |=> $stable(cw_o));

  // R6 R7
  one_cell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o || dn_o) |=> ($countones(cw_o ^ $past(cw_o)) <= 1));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_o && !dn_o) |=> $stable(cw_o));
endmodule

bind adpll_ctrl adpll_ctrl_chk #(.NCELL(NCELL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .err_code_o(err_code_o),
  .err_vld_o (err_vld_o),
  .up_o      (up_o),
  .dn_o      (dn_o),
  .cw_o      (cw_o)
);

// File: tb/adpll_ctrl_bench.sv
module adpll_ctrl_bench;
  localparam int M      = 4;
  localparam int NCELL  = 4;
  localparam int TREF   = (1 << M) * 920;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ref_i = 1'b0;
  logic [3:0]       err_code_o;
  logic             err_vld_o;
  logic [3:0]       corr_o;
  logic             up_o;
  logic             dn_o;
  logic [NCELL-1:0] cw_o;

  adpll_ctrl #(.DIV_W(M), .NCELL(NCELL), .CORR_MAX(4)) u_adpll_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_i     (ref_i),
    .err_code_o(err_code_o),
    .err_vld_o (err_vld_o),
    .corr_o    (corr_o),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .cw_o      (cw_o)
  );

  always #2 clk_i = ~clk_i;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int p);
    int top;
    top = p >> (M - 3);
    return (top < 4) ? -(top + 1) : (8 - top);
  endfunction

  function automatic int clamp4(input int v);
    return (v > 4) ? 4 : ((v < -4) ? -4 : v);
  endfunction

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // bench copy of elapsed clocks since reset release
  logic [M-1:0] pcount;
  always @(posedge clk_i) begin
    if (!rst_ni) pcount <= '0;
    else         pcount <= pcount + 1'b1;
  end

  // reference model state
  bit  ref_prev, vld_due, corr_due, loop_mode, seen_pos, seen_neg;
  int  code_due, prev_code, exp_corr, last_corr, pulses, n_fast, ref_idx;
  logic [NCELL-1:0] cw_prev;
  bit  pulse_prev;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      ref_prev = 0; vld_due = 0; corr_due = 0;
      prev_code = 0; last_corr = 0; pulses = 0; n_fast = 0;
      ref_idx = 0; cw_prev = '0; pulse_prev = 0;
    end else begin
      // R6 R7: fast-cell count follows pulse history with saturation
      chk($countones(cw_o) == n_fast, "R6 R7 cell count", $countones(cw_o), n_fast);
      // R8: no pulse last cycle means word unchanged
      if (!pulse_prev) chk(cw_o == cw_prev, "R8 hold", int'(cw_o), int'(cw_prev));
      chk(!(up_o && dn_o), "R5 exclusive", int'({up_o, dn_o}), 0);
      if (up_o && n_fast < NCELL) n_fast++;
      if (dn_o && n_fast > 0)     n_fast--;
      pulses     = pulses + int'(up_o) - int'(dn_o);
      pulse_prev = up_o | dn_o;
      cw_prev    = cw_o;

      if (corr_due) chk(int'($signed(corr_o)) == exp_corr, "R4 corr", int'($signed(corr_o)), exp_corr);
      corr_due = 0;

      if (vld_due) begin
        chk(err_vld_o == 1'b1, "R2 strobe", int'(err_vld_o), 1);
        chk(int'($signed(err_code_o)) == code_due, "R3 code", int'($signed(err_code_o)), code_due);
        chk(pulses == last_corr, "R5 pulse count", pulses, last_corr);
        pulses    = 0;
        exp_corr  = clamp4(2 * code_due - prev_code);
        prev_code = code_due;
        last_corr = exp_corr;
        corr_due  = 1;
        if (loop_mode) begin
          if (ref_idx == 0) chk(absi(code_due) == 4, "R9 initial", absi(code_due), 4);
          if (ref_idx >= 60) begin
            chk(absi(code_due) <= 3, "R9 bounded", absi(code_due), 3);
            if (code_due > 0) seen_pos = 1;
            if (code_due < 0) seen_neg = 1;
          end
          ref_idx++;
        end
      end else begin
        chk(err_vld_o == 1'b0, "R2 quiet", int'(err_vld_o), 0);
      end

      if (ref_i && !ref_prev) begin
        vld_due  = 1;
        code_due = exp_code(int'(pcount));
      end else begin
        vld_due = 0;
      end
      ref_prev = ref_i;
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    ref_i  = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1
    chk(cw_o == '0, "R1 cw", int'(cw_o), 0);
    chk(!up_o && !dn_o, "R1 pulses", int'({up_o, dn_o}), 0);
    chk(!err_vld_o, "R1 strobe", int'(err_vld_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic sweep(input int spacing, input int count);
    for (int i = 0; i < count; i++) begin
      @(posedge clk_i); #1 ref_i = 1'b1;
      @(posedge clk_i); #1 ref_i = 1'b0;
      repeat (spacing - 2) @(posedge clk_i);
    end
    repeat (12) @(posedge clk_i);
  endtask

  task automatic closed_loop(input int refs);
    int acc;
    acc = TREF / 2;
    for (int c = 0; c < refs * (1 << M); c++) begin
      @(posedge clk_i); #1;
      acc += 1000 - 40 * $countones(cw_o);
      if (acc >= TREF) begin
        acc  -= TREF;
        ref_i = 1'b1;
      end else begin
        ref_i = 1'b0;
      end
    end
  endtask

  initial begin
    loop_mode = 0; seen_pos = 0; seen_neg = 0;
    do_reset();
    sweep(17, 40);
    do_reset();
    sweep(13, 40);
    do_reset();
    sweep(19, 40);
    do_reset();
    loop_mode = 1;
    closed_loop(200);
    // R9
    chk(seen_pos && seen_neg, "R9 both signs", int'({seen_pos, seen_neg}), 3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule